// File: doc/BRIEF.md
# Masked Address Chip-Select Decoder

This block turns each bus access into one active-low select line, picked from eight channels. Channels 0 to 6 are general purpose. Channel 7 is the upper channel. Software gives every channel a start address and a mask. A set mask bit drops the matching address bit from the comparison, so masking low bits upward widens the region. Each channel is tagged as a memory or an I/O channel. That tag decides which address bits are compared, and it restricts the channel to cycles of its own kind.

A channel can also be tied to System Management Mode. When its SMM mask bit is clear, the SMM state of the access is compared like one more address bit. When that bit is set, the SMM state is ignored. The upper channel comes out of reset enabled and covering all of memory, so a boot device is reachable before any programming. A small register port writes the settings and reads them back.

Top module: `cs_decoder`

## Requirements
- R1: After reset every select is high. Channels 0 to 6 read zero in all four registers. Channel 7 reads 0x0000 in start-high, 0x0001 in start-low, 0x03FF in mask-high and 0x007F in mask-low.
- R2: `regAddr[4:2]` selects the channel, with 7 being the upper channel. `regAddr[1:0]` selects the register: 0 start-high, 1 start-low, 2 mask-high, 3 mask-low. A write takes effect at the clock edge where `regWr` is high. `regRdData` shows the addressed register without delay.
- R3: Both high registers hold their ten bits in bits 9:0. Start-low bit 0 is the memory flag (1 memory, 0 I/O), bits 5:1 are the lower start bits and bit 6 is the expected SMM state. Mask-low bit 0 is the enable, bits 5:1 are the lower mask bits and bit 6 is the SMM mask. Every other bit reads zero.
- R4: A set mask bit, high or low, excludes the matching address bit from the comparison. A clear mask bit requires that address bit to equal the start bit.
- R5: On a memory channel, the high fields compare with `busAddr[25:16]` and the low fields with `busAddr[15:11]`. The channel matches only when `busIsMem` is 1.
- R6: On an I/O channel, the high fields compare with `busAddr[15:6]` and the low fields with `busAddr[5:1]`. The channel matches only when `busIsMem` is 0.
- R7: A channel whose enable bit is 0 never drives its select low.
- R8: With the SMM mask set, `busSmm` is ignored. With it clear, a match also needs `busSmm` to equal the start-low SMM bit.
- R9: `csN` is registered. At the edge where `busValid` is 1 it takes the decode of that access. At the edge where `busValid` is 0 it goes all ones.
- R10: If several channels match, only the lowest-numbered one goes low. At most one select bit is ever low.
- R11: Until the first register write, every memory access selects channel 7 and every I/O access selects nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 5 | Channel (4:2) and register kind (1:0) |
| regWrData | input | 10 | Write data |
| regRdData | output | 16 | Read data of the addressed register |
| busValid | input | 1 | An access is presented this cycle |
| busIsMem | input | 1 | 1 for a memory access, 0 for an I/O access |
| busSmm | input | 1 | The processor is in SMM |
| busAddr | input | 25 | Access address bits 25:1 |
| csN | output | 8 | Active-low selects, bit n for channel n |

## Verification
The properties assume that the bus inputs hold steady around the edge that samples them. They also assume that a register write and the access it should affect fall in separate cycles, because a decode always uses the settings held before that edge. The directed stimulus changes inputs only on falling edges. It also gives every register write its own cycle before the access that depends on it. The boot property relies on a write-seen flag that its checker clears on reset.

// File: rtl/cs_pkg.sv
package cs_pkg;
  parameter int NUM_CH      = 8;
  parameter int HI_W        = 10;
  parameter int LO_W        = 5;
  parameter int MEM_HI_BASE = 16;
  parameter int IO_HI_BASE  = 6;
  parameter int RD_W        = 16;

  localparam int MEM_LO_BASE = MEM_HI_BASE - LO_W;
  localparam int IO_LO_BASE  = IO_HI_BASE - LO_W;
  localparam int ADDR_W      = MEM_HI_BASE + HI_W;
  localparam int CH_W        = $clog2(NUM_CH);
  localparam int REG_ADDR_W  = CH_W + 2;
  localparam int WR_W        = HI_W;
  localparam int UPPER_CH    = NUM_CH - 1;

  typedef enum logic [1:0] {
    KIND_START_HI = 2'd0,
    KIND_START_LO = 2'd1,
    KIND_MASK_HI  = 2'd2,
    KIND_MASK_LO  = 2'd3
  } regKind_t;

  typedef struct packed {
    logic [NUM_CH-1:0] startHiWr;
    logic [NUM_CH-1:0] startLoWr;
    logic [NUM_CH-1:0] maskHiWr;
    logic [NUM_CH-1:0] maskLoWr;
    logic [CH_W-1:0]   rdChan;
    regKind_t          rdKind;
  } regStrobe_t;
endpackage

// File: rtl/cs_ctrl.sv
module cs_ctrl
  import cs_pkg::*;
(
  input  logic                  regWr,
  input  logic [REG_ADDR_W-1:0] regAddr,
  output regStrobe_t            strobe
);
  logic [CH_W-1:0] chanSel;
  regKind_t        kindSel;

  assign chanSel = regAddr[REG_ADDR_W-1:2];
  assign kindSel = regKind_t'(regAddr[1:0]);

  always_comb begin
    strobe = '0;
    strobe.rdChan = chanSel;
    strobe.rdKind = kindSel;
    if (regWr) begin
      unique case (kindSel)
        KIND_START_HI: strobe.startHiWr[chanSel] = 1'b1;
        KIND_START_LO: strobe.startLoWr[chanSel] = 1'b1;
        KIND_MASK_HI:  strobe.maskHiWr[chanSel]  = 1'b1;
        KIND_MASK_LO:  strobe.maskLoWr[chanSel]  = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/cs_datapath.sv
module cs_datapath
  import cs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [WR_W-1:0]   regWrData,
  output logic [RD_W-1:0]   regRdData,
  input  logic              busValid,
  input  logic              busIsMem,
  input  logic              busSmm,
  input  logic [ADDR_W-1:1] busAddr,
  output logic [NUM_CH-1:0] csN
);
  logic [HI_W-1:0] startHi  [NUM_CH];
  logic [LO_W-1:0] startLo  [NUM_CH];
  logic            startMem [NUM_CH];
  logic            startSmm [NUM_CH];
  logic [HI_W-1:0] maskHi   [NUM_CH];
  logic [LO_W-1:0] maskLo   [NUM_CH];
  logic            chEn     [NUM_CH];
  logic            smmMask  [NUM_CH];

  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] grant;
  logic [HI_W-1:0]   cmpHi;
  logic [LO_W-1:0]   cmpLo;

  // Address slices are chosen once and shared by all channels.
  assign cmpHi = busIsMem ? busAddr[MEM_HI_BASE +: HI_W] : busAddr[IO_HI_BASE +: HI_W];
  assign cmpLo = busIsMem ? busAddr[MEM_LO_BASE +: LO_W] : busAddr[IO_LO_BASE +: LO_W];

  for (genvar i = 0; i < NUM_CH; i++) begin : gCh
    localparam bit IS_UPPER = (i == UPPER_CH);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        startHi[i]  <= '0;
        startLo[i]  <= '0;
        startSmm[i] <= 1'b0;
        startMem[i] <= IS_UPPER;
        maskHi[i]   <= IS_UPPER ? '1 : '0;
        maskLo[i]   <= IS_UPPER ? '1 : '0;
        smmMask[i]  <= IS_UPPER;
        chEn[i]     <= IS_UPPER;
      end else begin
        if (strobe.startHiWr[i]) startHi[i] <= regWrData[HI_W-1:0];
        if (strobe.startLoWr[i]) begin
          startMem[i] <= regWrData[0];
          startLo[i]  <= regWrData[LO_W:1];
          startSmm[i] <= regWrData[LO_W+1];
        end
        if (strobe.maskHiWr[i]) maskHi[i] <= regWrData[HI_W-1:0];
        if (strobe.maskLoWr[i]) begin
          chEn[i]    <= regWrData[0];
          maskLo[i]  <= regWrData[LO_W:1];
          smmMask[i] <= regWrData[LO_W+1];
        end
      end
    end

    assign hit[i] = chEn[i]
                  && (startMem[i] == busIsMem)
                  && (((cmpHi ^ startHi[i]) & ~maskHi[i]) == '0)
                  && (((cmpLo ^ startLo[i]) & ~maskLo[i]) == '0)
                  && (smmMask[i] || (busSmm == startSmm[i]));
  end

  // Fixed priority: the lowest channel number wins.
  always_comb begin
    grant = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (hit[i]) grant = NUM_CH'(1) << i;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         csN <= '1;
    else if (busValid) csN <= ~grant;
    else               csN <= '1;
  end

  always_comb begin
    regRdData = '0;
    unique case (strobe.rdKind)
      KIND_START_HI: regRdData[HI_W-1:0] = startHi[strobe.rdChan];
      KIND_START_LO: regRdData[LO_W+1:0] = {startSmm[strobe.rdChan],
                                            startLo[strobe.rdChan],
                                            startMem[strobe.rdChan]};
      KIND_MASK_HI:  regRdData[HI_W-1:0] = maskHi[strobe.rdChan];
      KIND_MASK_LO:  regRdData[LO_W+1:0] = {smmMask[strobe.rdChan],
                                            maskLo[strobe.rdChan],
                                            chEn[strobe.rdChan]};
    endcase
  end
endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
  import cs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWr,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [WR_W-1:0]       regWrData,
  output logic [RD_W-1:0]       regRdData,
  input  logic                  busValid,
  input  logic                  busIsMem,
  input  logic                  busSmm,
  input  logic [ADDR_W-1:1]     busAddr,
  output logic [NUM_CH-1:0]     csN
);
  regStrobe_t strobe;

  cs_ctrl uCtrl (
    .regWr   (regWr),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  cs_datapath uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .busValid  (busValid),
    .busIsMem  (busIsMem),
    .busSmm    (busSmm),
    .busAddr   (busAddr),
    .csN       (csN)
  );
endmodule

// File: rtl/cs_decoder_chk.sv
module cs_decoder_chk
  import cs_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWr,
  input logic [REG_ADDR_W-1:0] regAddr,
  input logic [WR_W-1:0]       regWrData,
  input logic [RD_W-1:0]       regRdData,
  input logic                  busValid,
  input logic                  busIsMem,
  input logic                  busSmm,
  input logic [ADDR_W-1:1]     busAddr,
  input logic [NUM_CH-1:0]     csN
);
  logic wroteAny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      wroteAny <= 1'b0;
    else if (regWr) wroteAny <= 1'b1;
  end

  // R10
  single_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> (csN == '1));

  // R11
  boot_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busIsMem && !wroteAny) |=> (csN == ~(NUM_CH'(1) << UPPER_CH)));

  // R11
  boot_io_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busIsMem && !wroteAny) |=> (csN == '1));

  // R2
  mask_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr[1:0] == 2'd2) |=>
      ((regAddr != $past(regAddr)) || (regRdData[HI_W-1:0] == $past(regWrData))));
endmodule

bind cs_decoder cs_decoder_chk uChk (.*);

// File: tb/cs_decoder_test.sv
module cs_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [9:0]  regWrData = '0;
  logic [15:0] regRdData;
  logic        busValid = 1'b0;
  logic        busIsMem = 1'b0;
  logic        busSmm = 1'b0;
  logic [25:1] busAddr = '0;
  logic [7:0]  csN;

  int total = 0;
  int bad = 0;
  bit doneFlag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_decoder uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .busValid(busValid),
    .busIsMem(busIsMem), .busSmm(busSmm), .busAddr(busAddr), .csN(csN)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input int ch, input int kind, input logic [9:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = 5'((ch << 2) | kind); regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdCheck(input string req, input int ch, input int kind, input logic [15:0] exp);
    @(negedge clk);
    regAddr = 5'((ch << 2) | kind);
    #1 check(req, regRdData, exp);
  endtask

  task automatic access(input string req, input logic isMem, input logic smm,
                        input logic [25:0] addr, input logic [7:0] exp);
    @(negedge clk);
    busValid = 1'b1; busIsMem = isMem; busSmm = smm; busAddr = addr[25:1];
    @(posedge clk);
    #1 check(req, {8'h00, csN}, {8'h00, exp});
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic testReset();
    check("R1 csN", {8'h00, csN}, 16'h00FF);
    rdCheck("R1 ch0 startHi", 0, 0, 16'h0000);
    rdCheck("R1 ch3 maskLo", 3, 3, 16'h0000);
    rdCheck("R1 ch7 startHi", 7, 0, 16'h0000);
    rdCheck("R1 ch7 startLo", 7, 1, 16'h0001);
    rdCheck("R1 ch7 maskHi", 7, 2, 16'h03FF);
    rdCheck("R1 ch7 maskLo", 7, 3, 16'h007F);
  endtask

  task automatic testBoot();
    access("R11 boot mem high", 1'b1, 1'b0, 26'h3FFFFFE, 8'h7F);
    access("R11 boot mem smm", 1'b1, 1'b1, 26'h0000000, 8'h7F);
    access("R11 boot io", 1'b0, 1'b0, 26'h0000340, 8'hFF);
  endtask

  task automatic testTiming();
    access("R9 valid edge", 1'b1, 1'b0, 26'h0001000, 8'h7F);
    @(posedge clk);
    #1 check("R9 release", {8'h00, csN}, 16'h00FF);
  endtask

  task automatic testRegMap();
    wrReg(5, 2, 10'h3FF);
    rdCheck("R2 R3 maskHi full", 5, 2, 16'h03FF);
    wrReg(5, 1, 10'h3FF);
    rdCheck("R3 startLo reserved", 5, 1, 16'h007F);
    wrReg(5, 0, 10'h2A5);
    rdCheck("R2 startHi", 5, 0, 16'h02A5);
    rdCheck("R2 other channel untouched", 4, 0, 16'h0000);
    wrReg(5, 3, 10'h3BE);
    rdCheck("R3 maskLo reserved", 5, 3, 16'h003E);
  endtask

  task automatic testMemory();
    // ch2: memory, 64 KiB at 0x0120000
    wrReg(2, 0, 10'h012);
    wrReg(2, 1, 10'h001);
    wrReg(2, 3, 10'h07F);
    access("R5 mem inside", 1'b1, 1'b0, 26'h0125678, 8'hFB);
    access("R5 mem outside", 1'b1, 1'b0, 26'h0130000, 8'h7F);
    access("R5 io cycle ignored", 1'b0, 1'b0, 26'h0125678, 8'hFF);
    wrReg(2, 2, 10'h001);
    access("R4 high mask widens", 1'b1, 1'b0, 26'h0130000, 8'hFB);
    access("R4 high mask limit", 1'b1, 1'b0, 26'h0140000, 8'h7F);
  endtask

  task automatic testLowMask();
    // ch4: memory at 0x0302000, address bits 12:11 masked
    wrReg(4, 0, 10'h030);
    wrReg(4, 1, 10'h009);
    wrReg(4, 3, 10'h047);
    access("R4 R5 low exact", 1'b1, 1'b0, 26'h0302000, 8'hEF);
    access("R4 low masked bits", 1'b1, 1'b0, 26'h0303800, 8'hEF);
    access("R4 low bit 14 differs", 1'b1, 1'b0, 26'h0304000, 8'h7F);
    access("R4 low bit 13 clear", 1'b1, 1'b0, 26'h0300000, 8'h7F);
  endtask

  task automatic testIo();
    // ch1: I/O at 0x0340, address bits 3:1 masked
    wrReg(1, 0, 10'h00D);
    wrReg(1, 1, 10'h000);
    wrReg(1, 3, 10'h04F);
    access("R6 io inside", 1'b0, 1'b0, 26'h0000346, 8'hFD);
    access("R6 io bit4 differs", 1'b0, 1'b0, 26'h0000350, 8'hFF);
    access("R6 io hi differs", 1'b0, 1'b0, 26'h0000380, 8'hFF);
    access("R6 mem cycle ignored", 1'b1, 1'b0, 26'h0000340, 8'h7F);
  endtask

  task automatic testSmm();
    // ch3: memory at 0x0200000, only inside SMM
    wrReg(3, 0, 10'h020);
    wrReg(3, 1, 10'h041);
    wrReg(3, 3, 10'h03F);
    access("R8 smm off no match", 1'b1, 1'b0, 26'h0200000, 8'h7F);
    access("R8 smm on match", 1'b1, 1'b1, 26'h0200000, 8'hF7);
    wrReg(3, 3, 10'h07F);
    access("R8 smm masked", 1'b1, 1'b0, 26'h0200000, 8'hF7);
  endtask

  task automatic testEnableAndPriority();
    // ch0 covers all memory but stays disabled
    wrReg(0, 1, 10'h001);
    wrReg(0, 2, 10'h3FF);
    wrReg(0, 3, 10'h07E);
    access("R7 disabled ch0", 1'b1, 1'b0, 26'h0125678, 8'hFB);
    wrReg(0, 3, 10'h07F);
    access("R10 ch0 beats ch2", 1'b1, 1'b0, 26'h0125678, 8'hFE);
    access("R10 ch0 beats ch7", 1'b1, 1'b0, 26'h3F00000, 8'hFE);
    wrReg(7, 3, 10'h07E);
    wrReg(0, 3, 10'h000);
    access("R7 disabled upper", 1'b1, 1'b0, 26'h3F00000, 8'hFF);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!doneFlag) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testBoot();
    testTiming();
    testRegMap();
    testMemory();
    testLowMask();
    testIo();
    testSmm();
    testEnableAndPriority();
    doneFlag = 1;
    finishRun();
  end
endmodule